// File: doc/BRIEF.md
# DRAM Strobe Mode Decoder

This block is the synthesizable control model of a 16-bit-wide, two-byte-lane dynamic RAM's mode-control logic. It samples the active-low strobes on a fast system clock: the row strobe, the lower and upper column strobes, write enable and output enable. It detects their falling and rising edges and works out from their relative order which kind of memory cycle is running. It latches the row and column addresses and produces one write strobe per byte lane at the data latch point. It also decides per lane whether the data output drivers are on. An internal refresh row counter supplies the row for the refresh modes that need no external row address.

The block is used in front of a behavioural storage array. The array takes `row_addr`, `col_addr`, `lane_wr` and `wr_data` to write, and it drives read data only on the lanes where `dq_oe` is set. Each time the row strobe rises, the block reports the kind of the finished cycle as a 3-bit code and pulses `cycle_done`. In a page-mode cycle the reported kind is that of the last column access.

State machine: `ST_IDLE` (row strobe high), `ST_ROW_OPEN` (row latched, no column strobe yet), `ST_ACCESS` (column access in progress), `ST_PAGE` (row held open, column strobes high between page accesses), `ST_CBR` (refresh started with a column strobe already low), `ST_CBR_GAP` (column strobes released after that refresh, row strobe still low), `ST_TEST_ACCESS` (counter-test column access) and `ST_HIDDEN` (hidden refresh).

Transitions:
- Row strobe falls in `ST_IDLE` with both column strobes high: the block goes to `ST_ROW_OPEN`.
- Row strobe falls in `ST_IDLE` with a column strobe low: the block goes to `ST_CBR`, or to `ST_HIDDEN` if that strobe has stayed low since a previous access.
- A column strobe falls in `ST_ROW_OPEN` or `ST_PAGE`: the block goes to `ST_ACCESS`.
- Both column strobes go high in `ST_ACCESS`: the block goes to `ST_PAGE`.
- Both column strobes go high in `ST_CBR` or `ST_TEST_ACCESS`: the block goes to `ST_CBR_GAP`.
- A column strobe falls in `ST_CBR_GAP`: the block goes to `ST_TEST_ACCESS`.
- The row strobe rises in any state other than `ST_IDLE`: the block returns to `ST_IDLE`.

Top module: `strobe_mode_decoder`

## Requirements
- R1: After reset, `row_addr`, `col_addr`, `lane_wr`, `dq_oe`, `cycle_kind` and `cycle_done` are all zero and the refresh counter is zero. Every registered output changes in the clock cycle after the sample that sees the input change.
- R2: A row strobe fall with both column strobes high latches `addr` as the row. If no column strobe falls before the row strobe rises, the cycle is reported as a row-only refresh, code 4.
- R3: A column strobe that is low in the same sample as the row strobe fall, or earlier, starts a counter refresh, code 5. The row is the refresh counter value, and the counter then increments modulo 2^ADDR_W.
- R4: When write enable is low at a lane's column strobe fall (early write), that lane's `lane_wr` bit pulses for one cycle and its `wr_data` lane holds `din` from the fall. An access that starts this way is reported as code 1.
- R5: When write enable falls after the column strobe and output enable has not been low during the access, the write strobe and the data capture occur at the write enable fall. The access is reported as a delayed write, code 2.
- R6: When write enable falls after the column strobe and output enable was low at some point of the access before it, the access is reported as a read-modify-write, code 3.
- R7: A column strobe held low from an access through the row strobe's rise and next fall starts a hidden refresh, code 6. The row comes from the refresh counter, the counter increments, and the output drive is kept.
- R8: After a counter refresh, a column strobe rise and a new fall while the row strobe stays low start a counter-test access, code 7. The column is latched from `addr` at that fall, the row stays the counter row, and writes follow R4 and R5.
- R9: A lane's `dq_oe` turns on in a read access while its column strobe is low, output enable is low and write enable is high. It stays on while the column strobes are high in page mode. It turns off when output enable is high, when write enable is low, or when the row strobe and that lane's column strobe are both high.
- R10: In page mode each column strobe fall latches a new column while `row_addr` keeps its value. The kind reported at the row strobe rise is that of the last access.
- R11: `cycle_done` is a one-cycle pulse in the cycle after the row strobe rise is sampled, and `cycle_kind` holds the finished cycle's code. Code 0 is a read.
- R12: Lane 0 is `din`/`wr_data` bits [LANE_W-1:0] under the lower column strobe, and lane 1 is the upper half under the upper column strobe. Each lane writes only on its own strobe's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower lane column strobe, active low |
| ucas_n | input | 1 | Upper lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 2*LANE_W | Write data, two byte lanes |
| row_addr | output | ADDR_W | Latched row |
| col_addr | output | ADDR_W | Latched column |
| lane_wr | output | 2 | Per-lane write strobe pulse |
| wr_data | output | 2*LANE_W | Data captured at the latch point |
| dq_oe | output | 2 | Per-lane output drive decision |
| cycle_kind | output | 3 | Code of the last finished cycle |
| cycle_done | output | 1 | One-cycle pulse at cycle end |

## Verification
The bench builds the block with ADDR_W=3 and LANE_W=8, so the array has 8 rows and 8 columns. That size lets every location be written in early-write page mode and read back in read page mode, with data computed from the row and column. The refresh counter wraps inside ten counter refreshes, so the wrap from 7 to 0 is checked directly. Delayed write, read-modify-write, single-lane writes, hidden refresh and the counter-test access are each run on top of this sweep, and their expected codes, rows and data are derived from the stimulus.

// File: rtl/smd_pkg.sv
package smd_pkg;

    // Cycle classification codes reported at the end of a row cycle
    typedef enum logic [2:0] {
        CK_READ       = 3'd0,
        CK_EARLY_WR   = 3'd1,
        CK_DELAYED_WR = 3'd2,
        CK_RMW        = 3'd3,
        CK_RAS_ONLY   = 3'd4,
        CK_CBR        = 3'd5,
        CK_HIDDEN     = 3'd6,
        CK_CTR_TEST   = 3'd7
    } ck_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_ACCESS,
        ST_PAGE,
        ST_CBR,
        ST_CBR_GAP,
        ST_TEST_ACCESS,
        ST_HIDDEN
    } st_e;

    // Bit positions inside the falling-edge vector
    localparam int unsigned FI_RAS  = 0;
    localparam int unsigned FI_LCAS = 1;
    localparam int unsigned FI_UCAS = 2;
    localparam int unsigned FI_WE   = 3;
    localparam int unsigned FI_CAS  = 4;
    localparam int unsigned FALL_N  = 5;

    // Bit positions inside the rising-edge vector
    localparam int unsigned RI_RAS  = 0;
    localparam int unsigned RI_CAS  = 1;
    localparam int unsigned RISE_N  = 2;

    localparam int unsigned LANES   = 2;

endpackage

// File: rtl/smd_edge_bank.sv
module smd_edge_bank #(
    parameter int unsigned N      = 1,
    parameter bit          RISING = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] evt
);

    logic [N-1:0] prev_q;

    // Strobes idle high, so the history starts high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= lvl;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign evt = lvl & ~prev_q;
        end else begin : g_fall
            assign evt = prev_q & ~lvl;
        end
    endgenerate

endmodule

// File: rtl/smd_refresh_ctr.sv
module smd_refresh_ctr #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] count
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/smd_cycle_fsm.sv
module smd_cycle_fsm
    import smd_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ras_fall,
    input  logic                    ras_rise,
    input  logic                    cas_fall,
    input  logic                    cas_rise,
    input  logic [LANES-1:0]        lane_fall,
    input  logic [LANES-1:0]        lane_low,
    input  logic                    ras_high,
    input  logic                    we_low,
    input  logic                    we_fall,
    input  logic                    oe_low,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [ADDR_W-1:0]       ref_row,
    output logic                    ref_step,
    output logic [ADDR_W-1:0]       row_addr,
    output logic [ADDR_W-1:0]       col_addr,
    output logic [LANES-1:0]        lane_wr,
    output logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES-1:0]        dq_oe,
    output logic [2:0]              cycle_kind,
    output logic                    cycle_done
);

    localparam int unsigned DW = LANES * LANE_W;

    st_e                 state_q, state_d;
    ck_e                 kind_q, kind_d;
    ck_e                 done_kind_q, done_kind_d;
    logic                early_q, early_d;
    logic                oe_seen_q, oe_seen_d;
    logic                held_q, held_d;
    logic [ADDR_W-1:0]   row_q, row_d;
    logic [ADDR_W-1:0]   col_q, col_d;
    logic [LANES-1:0]    drv_q, drv_d;
    logic [LANES-1:0]    wr_q, wr_d;
    logic [DW-1:0]       wdata_q, wdata_d;
    logic                done_q, done_d;
    logic                cas_low;
    logic                access_next;

    assign cas_low = |lane_low;

    // Next-state and cycle classification
    always_comb begin
        state_d     = state_q;
        kind_d      = kind_q;
        done_kind_d = done_kind_q;
        early_d     = early_q;
        oe_seen_d   = oe_seen_q | oe_low;
        held_d      = held_q & cas_low;
        row_d       = row_q;
        col_d       = col_q;
        done_d      = 1'b0;
        ref_step    = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (cas_low) begin
                        ref_step = 1'b1;
                        row_d    = ref_row;
                        if (held_q) begin
                            state_d = ST_HIDDEN;
                            kind_d  = CK_HIDDEN;
                        end else begin
                            state_d = ST_CBR;
                            kind_d  = CK_CBR;
                        end
                    end else begin
                        row_d   = addr;
                        state_d = ST_ROW_OPEN;
                        kind_d  = CK_RAS_ONLY;
                    end
                end
            end

            ST_ROW_OPEN, ST_PAGE: begin
                if (ras_rise) begin
                    state_d     = ST_IDLE;
                    done_d      = 1'b1;
                    done_kind_d = kind_q;
                    held_d      = 1'b0;
                end else if (cas_fall) begin
                    state_d   = ST_ACCESS;
                    col_d     = addr;
                    early_d   = we_low;
                    oe_seen_d = oe_low;
                    kind_d    = we_low ? CK_EARLY_WR : CK_READ;
                end
            end

            ST_ACCESS, ST_TEST_ACCESS: begin
                if (ras_rise) begin
                    state_d     = ST_IDLE;
                    done_d      = 1'b1;
                    done_kind_d = kind_q;
                    held_d      = cas_low;
                end else begin
                    if (we_fall && !early_q && kind_q == CK_READ) begin
                        kind_d = oe_seen_q ? CK_RMW : CK_DELAYED_WR;
                    end
                    if (cas_rise) begin
                        state_d = (state_q == ST_ACCESS) ? ST_PAGE : ST_CBR_GAP;
                    end
                end
            end

            ST_CBR, ST_CBR_GAP: begin
                if (ras_rise) begin
                    state_d     = ST_IDLE;
                    done_d      = 1'b1;
                    done_kind_d = kind_q;
                    held_d      = 1'b0;
                end else if (state_q == ST_CBR && cas_rise) begin
                    state_d = ST_CBR_GAP;
                end else if (state_q == ST_CBR_GAP && cas_fall) begin
                    state_d   = ST_TEST_ACCESS;
                    col_d     = addr;
                    early_d   = we_low;
                    oe_seen_d = oe_low;
                    kind_d    = CK_CTR_TEST;
                end
            end

            ST_HIDDEN: begin
                if (ras_rise) begin
                    state_d     = ST_IDLE;
                    done_d      = 1'b1;
                    done_kind_d = kind_q;
                    held_d      = cas_low;
                end
            end
        endcase
    end

    assign access_next = (state_d == ST_ACCESS) || (state_d == ST_TEST_ACCESS);

    // Per-lane drive and write strobes
    always_comb begin
        drv_d   = drv_q;
        wr_d    = '0;
        wdata_d = wdata_q;
        for (int i = 0; i < LANES; i++) begin
            if (!oe_low || we_low || (ras_high && !lane_low[i])) begin
                drv_d[i] = 1'b0;
            end else if (access_next && lane_low[i] && !early_d) begin
                drv_d[i] = 1'b1;
            end
            wr_d[i] = access_next &&
                      ((lane_fall[i] && we_low) || (we_fall && lane_low[i]));
            if (wr_d[i]) begin
                wdata_d[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            kind_q      <= CK_READ;
            done_kind_q <= CK_READ;
            early_q     <= 1'b0;
            oe_seen_q   <= 1'b0;
            held_q      <= 1'b0;
            row_q       <= '0;
            col_q       <= '0;
            drv_q       <= '0;
            wr_q        <= '0;
            wdata_q     <= '0;
            done_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            kind_q      <= kind_d;
            done_kind_q <= done_kind_d;
            early_q     <= early_d;
            oe_seen_q   <= oe_seen_d;
            held_q      <= held_d;
            row_q       <= row_d;
            col_q       <= col_d;
            drv_q       <= drv_d;
            wr_q        <= wr_d;
            wdata_q     <= wdata_d;
            done_q      <= done_d;
        end
    end

    assign row_addr   = row_q;
    assign col_addr   = col_q;
    assign lane_wr    = wr_q;
    assign wr_data    = wdata_q;
    assign dq_oe      = drv_q;
    assign cycle_kind = done_kind_q;
    assign cycle_done = done_q;

endmodule

// File: rtl/strobe_mode_decoder.sv
module strobe_mode_decoder
    import smd_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ras_n,
    input  logic                    lcas_n,
    input  logic                    ucas_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2*LANE_W-1:0]     din,
    output logic [ADDR_W-1:0]       row_addr,
    output logic [ADDR_W-1:0]       col_addr,
    output logic [1:0]              lane_wr,
    output logic [2*LANE_W-1:0]     wr_data,
    output logic [1:0]              dq_oe,
    output logic [2:0]              cycle_kind,
    output logic                    cycle_done
);

    logic               cas_any_n;
    logic [FALL_N-1:0]  fall_lvl, fall_evt;
    logic [RISE_N-1:0]  rise_lvl, rise_evt;
    logic [ADDR_W-1:0]  ref_row;
    logic               ref_step;

    assign cas_any_n = lcas_n & ucas_n;

    always_comb begin
        fall_lvl          = '1;
        fall_lvl[FI_RAS]  = ras_n;
        fall_lvl[FI_LCAS] = lcas_n;
        fall_lvl[FI_UCAS] = ucas_n;
        fall_lvl[FI_WE]   = we_n;
        fall_lvl[FI_CAS]  = cas_any_n;
        rise_lvl          = '0;
        rise_lvl[RI_RAS]  = ras_n;
        rise_lvl[RI_CAS]  = cas_any_n;
    end

    smd_edge_bank #(.N(FALL_N), .RISING(1'b0)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (fall_lvl),
        .evt   (fall_evt)
    );

    smd_edge_bank #(.N(RISE_N), .RISING(1'b1)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (rise_lvl),
        .evt   (rise_evt)
    );

    smd_refresh_ctr #(.W(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ref_step),
        .count (ref_row)
    );

    smd_cycle_fsm #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_fall   (fall_evt[FI_RAS]),
        .ras_rise   (rise_evt[RI_RAS]),
        .cas_fall   (fall_evt[FI_CAS]),
        .cas_rise   (rise_evt[RI_CAS]),
        .lane_fall  ({fall_evt[FI_UCAS], fall_evt[FI_LCAS]}),
        .lane_low   ({~ucas_n, ~lcas_n}),
        .ras_high   (ras_n),
        .we_low     (~we_n),
        .we_fall    (fall_evt[FI_WE]),
        .oe_low     (~oe_n),
        .addr       (addr),
        .din        (din),
        .ref_row    (ref_row),
        .ref_step   (ref_step),
        .row_addr   (row_addr),
        .col_addr   (col_addr),
        .lane_wr    (lane_wr),
        .wr_data    (wr_data),
        .dq_oe      (dq_oe),
        .cycle_kind (cycle_kind),
        .cycle_done (cycle_done)
    );

endmodule

// File: rtl/smd_checker.sv
module smd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic       lcas_n,
    input logic       ucas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic [1:0] lane_wr,
    input logic [1:0] dq_oe,
    input logic       cycle_done
);

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    // R11: completion follows a sampled row strobe rise
    p_done_after_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> ($past(ras_n) && !$past(ras_n, 2)));

    // R12: lower lane writes only with its own strobe low and write enable low
    p_lo_lane_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lane_wr[0] |-> (!$past(lcas_n) && !$past(we_n)));

    // R12: upper lane writes only with its own strobe low and write enable low
    p_hi_lane_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lane_wr[1] |-> (!$past(ucas_n) && !$past(we_n)));

    // R9: drive needs output enable low and write enable high
    p_drive_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 2'b00) |-> (!$past(oe_n) && $past(we_n)));

    // R9: a write strobe never coincides with driven outputs
    p_write_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr != 2'b00) |-> (dq_oe == 2'b00));

endmodule

bind strobe_mode_decoder smd_checker u_smd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .lcas_n     (lcas_n),
    .ucas_n     (ucas_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .lane_wr    (lane_wr),
    .dq_oe      (dq_oe),
    .cycle_done (cycle_done)
);

// File: tb/strobe_mode_decoder_bench.sv
`timescale 1ns/1ps
module strobe_mode_decoder_bench;

    localparam int AW = 3;
    localparam int LW = 8;
    localparam int DW = 2 * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1;
    logic          we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] row_addr, col_addr;
    logic [1:0]    lane_wr, dq_oe;
    logic [DW-1:0] wr_data;
    logic [2:0]    cycle_kind;
    logic          cycle_done;

    int total = 0;
    int bad = 0;
    int ref_cnt = 0;
    bit finished = 0;

    logic [DW-1:0] mem [0:(1<<(2*AW))-1];

    always #4 clk = ~clk;

    strobe_mode_decoder #(.ADDR_W(AW), .LANE_W(LW)) u_strobe_mode_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .row_addr(row_addr), .col_addr(col_addr), .lane_wr(lane_wr),
        .wr_data(wr_data), .dq_oe(dq_oe), .cycle_kind(cycle_kind),
        .cycle_done(cycle_done)
    );

    // Behavioural storage driven only by the block's outputs
    always @(posedge clk) begin
        if (lane_wr[0]) mem[{row_addr, col_addr}][LW-1:0]  <= wr_data[LW-1:0];
        if (lane_wr[1]) mem[{row_addr, col_addr}][DW-1:LW] <= wr_data[DW-1:LW];
    end

    function automatic logic [DW-1:0] pat(input int r, input int c);
        pat = DW'((r * 8 + c) * 16'h0101) ^ 16'h5A3C;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ras_lo(input int r);
        addr = AW'(r);
        ras_n = 1'b0;
        step();
    endtask

    task automatic ras_hi(input string req, input int kind);
        ras_n = 1'b1;
        step();
        chk(req, 32'(cycle_done), 1);
        chk(req, 32'(cycle_kind), 32'(kind));
        step();
        chk("R11", 32'(cycle_done), 0);
    endtask

    task automatic cas_lo(input logic [1:0] lanes, input int c);
        addr = AW'(c);
        lcas_n = ~lanes[0];
        ucas_n = ~lanes[1];
        step();
    endtask

    task automatic cas_hi();
        lcas_n = 1'b1;
        ucas_n = 1'b1;
        step();
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            report();
        end
    end

    initial begin
        for (int i = 0; i < (1 << (2*AW)); i++) mem[i] = '0;
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        chk("R1", 32'(row_addr), 0);
        chk("R1", 32'(col_addr), 0);
        chk("R1", 32'(lane_wr), 0);
        chk("R1", 32'(dq_oe), 0);
        chk("R1", 32'(cycle_done), 0);
        chk("R1", 32'(cycle_kind), 0);

        // R4 / R10: early-write page sweep over every location
        for (int r = 0; r < (1 << AW); r++) begin
            ras_lo(r);
            chk("R2", 32'(row_addr), 32'(r));
            we_n = 1'b0;
            for (int c = 0; c < (1 << AW); c++) begin
                din = pat(r, c);
                cas_lo(2'b11, c);
                chk("R10", 32'(col_addr), 32'(c));
                chk("R10", 32'(row_addr), 32'(r));
                chk("R4", 32'(lane_wr), 3);
                chk("R4", 32'(wr_data), 32'(pat(r, c)));
                cas_hi();
                chk("R4", 32'(lane_wr), 0);
            end
            we_n = 1'b1;
            ras_hi("R11", 1);
        end

        // R9 / R10: read page sweep with output hold between strobes
        oe_n = 1'b0;
        for (int r = 0; r < (1 << AW); r++) begin
            ras_lo(r);
            for (int c = 0; c < (1 << AW); c++) begin
                cas_lo(2'b11, c);
                chk("R9", 32'(dq_oe), 3);
                chk("R4", 32'(mem[{row_addr, col_addr}]), 32'(pat(r, c)));
                cas_hi();
                chk("R9", 32'(dq_oe), 3);
            end
            ras_hi("R11", 0);
            chk("R9", 32'(dq_oe), 0);
        end
        oe_n = 1'b1;

        // R5: delayed write latches data at the write enable fall
        ras_lo(5);
        din = 16'h0000;
        cas_lo(2'b11, 2);
        chk("R5", 32'(lane_wr), 0);
        din = 16'hABCD;
        we_n = 1'b0;
        step();
        chk("R5", 32'(lane_wr), 3);
        chk("R5", 32'(wr_data), 32'h0000ABCD);
        we_n = 1'b1;
        cas_hi();
        ras_hi("R5", 2);
        chk("R5", 32'(mem[{3'd5, 3'd2}]), 32'h0000ABCD);

        // R6: read-modify-write, OE high turns drive off (R9)
        oe_n = 1'b0;
        ras_lo(6);
        cas_lo(2'b11, 3);
        chk("R9", 32'(dq_oe), 3);
        oe_n = 1'b1;
        step();
        chk("R9", 32'(dq_oe), 0);
        din = 16'h1234;
        we_n = 1'b0;
        step();
        chk("R6", 32'(lane_wr), 3);
        we_n = 1'b1;
        cas_hi();
        ras_hi("R6", 3);
        chk("R6", 32'(mem[{3'd6, 3'd3}]), 32'h00001234);

        // R12: independent lanes
        ras_lo(1);
        we_n = 1'b0;
        din = 16'hEEEE;
        cas_lo(2'b01, 4);
        chk("R12", 32'(lane_wr), 1);
        din = 16'h7777;
        ucas_n = 1'b0;
        step();
        chk("R12", 32'(lane_wr), 2);
        chk("R12", 32'(wr_data), 32'h000077EE);
        cas_hi();
        we_n = 1'b1;
        ras_hi("R12", 1);
        chk("R12", 32'(mem[{3'd1, 3'd4}]), 32'h000077EE);

        // R2: row-only refresh
        ras_lo(3);
        step();
        chk("R2", 32'(row_addr), 3);
        chk("R2", 32'(lane_wr), 0);
        ras_hi("R2", 4);

        // R3: counter refresh sweep with wrap; last one with simultaneous edges
        for (int i = 0; i < 10; i++) begin
            if (i == 9) begin
                lcas_n = 1'b0;
                ras_n = 1'b0;
                step();
            end else begin
                lcas_n = 1'b0;
                step();
                ras_n = 1'b0;
                step();
            end
            chk("R3", 32'(row_addr), 32'(ref_cnt));
            ras_hi("R3", 5);
            lcas_n = 1'b1;
            step();
            ref_cnt = (ref_cnt + 1) % (1 << AW);
        end

        // R7: hidden refresh keeps the read data driven
        oe_n = 1'b0;
        ras_lo(2);
        cas_lo(2'b11, 6);
        chk("R7", 32'(dq_oe), 3);
        ras_hi("R11", 0);
        chk("R7", 32'(dq_oe), 3);
        ras_n = 1'b0;
        step();
        chk("R7", 32'(row_addr), 32'(ref_cnt));
        chk("R7", 32'(dq_oe), 3);
        ras_hi("R7", 6);
        ref_cnt = (ref_cnt + 1) % (1 << AW);
        cas_hi();
        chk("R9", 32'(dq_oe), 0);
        oe_n = 1'b1;

        // R8: counter-test access writes at the counter row
        begin
            int trow;
            lcas_n = 1'b0;
            ucas_n = 1'b0;
            step();
            ras_n = 1'b0;
            step();
            trow = ref_cnt;
            chk("R8", 32'(row_addr), 32'(trow));
            ref_cnt = (ref_cnt + 1) % (1 << AW);
            cas_hi();
            we_n = 1'b0;
            din = 16'hC0DE;
            cas_lo(2'b11, 7);
            chk("R8", 32'(lane_wr), 3);
            chk("R8", 32'(col_addr), 7);
            chk("R8", 32'(row_addr), 32'(trow));
            we_n = 1'b1;
            cas_hi();
            ras_hi("R8", 7);
            chk("R8", 32'(mem[{AW'(trow), 3'd7}]), 32'h0000C0DE);
        end

        // R3: counter advanced past the test access
        lcas_n = 1'b0;
        step();
        ras_n = 1'b0;
        step();
        chk("R3", 32'(row_addr), 32'(ref_cnt));
        ras_hi("R3", 5);
        lcas_n = 1'b1;
        step();

        finished = 1;
        report();
    end

endmodule